// File: doc/BRIEF.md
# Microstep Control Sequencer

This block is the control unit for a small accumulator processor. The datapath has a program counter P, an accumulator A, a temporary register T, an operand register R with its bitwise complement N, and one shared adder. The adder output also serves as the memory address. Every instruction starts with a fetch cycle. Fetch reads memory at P into the instruction register I and advances P. The sequencer then decodes the low bits of I and walks through that opcode's fixed list of register-transfer microsteps, one per clock. After the last microstep it returns to fetch.

In each cycle the block drives a combination of lines:

- Operand selects for the adder's left side (P or A) and right side (R or N).
- A drive enable that puts T on the data bus.
- A memory read enable and a memory write strobe.
- Load strobes for P, A, the R/N pair and T.
- The adder carry-in.
- A P post-increment strobe.
- An instruction-load strobe.

Subtraction is A + N + 1, with N equal to the complement of R.

The I register sits outside this block and is read through `instrIn`. Only bits 2:0 select the opcode.

Top module: `microSeq`

## Requirements
- R1: While rstN is low, and in the first cycle after it goes high, the outputs show the fetch microstep. Reset is asynchronous, so lowering rstN in the middle of an instruction switches the outputs to fetch at once.
- R2: Fetch lasts one cycle and asserts exactly selP, memRead, pInc and iLoad. The next cycle is microstep 0 of the opcode in instrIn[2:0]: 0 add-immediate, 1 add-memory, 2 load-immediate, 3 store, 4 store-keep, 5 jump, 6 move, 7 subtract.
- R3: Add-immediate (opcode 0) runs two steps. Step 0 asserts {selP, memRead, clkRN, pInc}. Step 1 asserts {selA, selR, clkA}.
- R4: Add-memory (opcode 1) runs three steps: {selP, memRead, clkRN, pInc}, then {selR, memRead, clkRN}, then {selA, selR, clkA}.
- R5: Load-immediate (opcode 2) runs two steps: {selP, memRead, clkRN, pInc}, then {selR, clkA}.
- R6: Store (opcode 3) runs three steps: {selA, clkT}, then {selP, memRead, clkA, pInc}, then {selA, driveT, memWrite}. Store-keep (opcode 4) runs the same three steps and then two more: {driveT, clkRN}, then {selR, clkA}.
- R7: Jump (opcode 5) runs two steps: {selP, memRead, clkRN, pInc}, then {selP, selR, clkP}.
- R8: Move (opcode 6) runs five steps, in this order:
  - {selP, memRead, clkRN, pInc}
  - {selR, memRead, clkT}
  - {selP, memRead, clkRN, pInc}
  - {selR, clkA}
  - {selA, driveT, memWrite}
- R9: Subtract (opcode 7) runs two steps: {selP, memRead, clkRN, pInc}, then {selA, selN, carryIn, clkA}. carryIn is asserted in no other step.
- R10: The cycle after an opcode's last step is fetch. In every step, all lines not listed for that step are 0.
- R11: memRead and memWrite are never high together. selP and selA are never high together. selR and selN are never high together.
- R12: Bits of instrIn above bit 2 have no effect on any output.
- R13: If I changes during execution so that the current step index lies past the new opcode's last step, all lines go to 0 for the rest of that cycle, and the next cycle is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrIn | input | INSTR_W | Contents of the instruction register |
| selP | output | 1 | P onto the adder left input |
| selA | output | 1 | A onto the adder left input |
| selR | output | 1 | R onto the adder right input |
| selN | output | 1 | N (inverted R) onto the adder right input |
| driveT | output | 1 | T onto the data bus |
| memRead | output | 1 | Memory read enable |
| clkP | output | 1 | Load P from the adder |
| clkA | output | 1 | Load A |
| clkRN | output | 1 | Load the R/N pair |
| clkT | output | 1 | Load T |
| memWrite | output | 1 | Memory write strobe |
| carryIn | output | 1 | Adder carry-in |
| pInc | output | 1 | Post-increment P |
| iLoad | output | 1 | Load I from memory |

## Verification
Some properties are checked on every cycle by assertions:

- No read/write clash and no double operand select.
- carryIn only appears together with selN.
- pInc only appears with a read at P.
- Fetch never repeats back to back, and execution always starts at step 0.
- The step counter stays inside its bound.

Other behaviour can only be shown by the bench's scenarios, because it depends on which opcode was loaded:

- The exact strobe pattern and length of every opcode's sequence, swept over all upper-bit values of I.
- The fallback when I changes in the middle of an instruction.
- An asynchronous reset during execution.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int OP_W      = 3;
  localparam int MAX_STEPS = 5;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  typedef enum logic [OP_W-1:0] {
    OP_ADDI = 3'd0,
    OP_ADDM = 3'd1,
    OP_LDI  = 3'd2,
    OP_ST   = 3'd3,
    OP_STK  = 3'd4,
    OP_JMP  = 3'd5,
    OP_MOV  = 3'd6,
    OP_SUB  = 3'd7
  } opT;

  // One register transfer per microstep
  typedef enum logic [3:0] {
    UOP_IDLE,
    UOP_FETCH,
    UOP_IMM_TO_RN,   // mem[P++] -> R/N
    UOP_ADD_AR,      // A+R -> A
    UOP_IND_TO_RN,   // mem[R] -> R/N
    UOP_R_TO_A,      // 0+R -> A
    UOP_A_TO_T,      // A -> T
    UOP_IMM_TO_A,    // mem[P++] -> A
    UOP_T_TO_MEM,    // T -> mem[A]
    UOP_T_TO_RN,     // T -> R/N
    UOP_JUMP,        // P+R -> P
    UOP_IND_TO_T,    // mem[R] -> T
    UOP_SUB_AN       // A+N+1 -> A
  } uopT;

  typedef struct packed {
    logic selP;
    logic selA;
    logic selR;
    logic selN;
    logic driveT;
    logic memRead;
    logic clkP;
    logic clkA;
    logic clkRN;
    logic clkT;
    logic memWrite;
    logic carryIn;
    logic pInc;
    logic iLoad;
  } strobeT;

  function automatic int seqLen(opT op);
    case (op)
      OP_ADDM, OP_ST:  return 3;
      OP_STK,  OP_MOV: return 5;
      default:         return 2;
    endcase
  endfunction
endpackage

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opBits,
  output uopT             uopOut
);
  logic              inFetch;
  logic [STEP_W-1:0] stepIdx;
  logic              lastStep;
  uopT               romUop;
  opT                curOp;
  int                s;

  assign curOp = opT'(opBits);

  // Microprogram lookup: (opcode, step) -> transfer
  always_comb begin
    s        = int'(stepIdx);
    romUop   = UOP_IDLE;
    lastStep = (s >= seqLen(curOp) - 1);
    case (curOp)
      OP_ADDI: case (s)
        0: romUop = UOP_IMM_TO_RN;
        1: romUop = UOP_ADD_AR;
        default: romUop = UOP_IDLE;
      endcase
      OP_ADDM: case (s)
        0: romUop = UOP_IMM_TO_RN;
        1: romUop = UOP_IND_TO_RN;
        2: romUop = UOP_ADD_AR;
        default: romUop = UOP_IDLE;
      endcase
      OP_LDI: case (s)
        0: romUop = UOP_IMM_TO_RN;
        1: romUop = UOP_R_TO_A;
        default: romUop = UOP_IDLE;
      endcase
      OP_ST, OP_STK: case (s)
        0: romUop = UOP_A_TO_T;
        1: romUop = UOP_IMM_TO_A;
        2: romUop = UOP_T_TO_MEM;
        3: romUop = (curOp == OP_STK) ? UOP_T_TO_RN : UOP_IDLE;
        4: romUop = (curOp == OP_STK) ? UOP_R_TO_A : UOP_IDLE;
        default: romUop = UOP_IDLE;
      endcase
      OP_JMP: case (s)
        0: romUop = UOP_IMM_TO_RN;
        1: romUop = UOP_JUMP;
        default: romUop = UOP_IDLE;
      endcase
      OP_MOV: case (s)
        0: romUop = UOP_IMM_TO_RN;
        1: romUop = UOP_IND_TO_T;
        2: romUop = UOP_IMM_TO_RN;
        3: romUop = UOP_R_TO_A;
        4: romUop = UOP_T_TO_MEM;
        default: romUop = UOP_IDLE;
      endcase
      OP_SUB: case (s)
        0: romUop = UOP_IMM_TO_RN;
        1: romUop = UOP_SUB_AN;
        default: romUop = UOP_IDLE;
      endcase
      default: romUop = UOP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFetch <= 1'b1;
      stepIdx <= '0;
    end else if (inFetch) begin
      inFetch <= 1'b0;
      stepIdx <= '0;
    end else if (lastStep) begin
      inFetch <= 1'b1;
      stepIdx <= '0;
    end else begin
      stepIdx <= stepIdx + STEP_W'(1);
    end
  end

  assign uopOut = inFetch ? UOP_FETCH : romUop;

  // R10: fetch is a single cycle, always followed by execution
  a_r10_fetch_single: assert property (@(posedge clk) disable iff (!rstN)
    inFetch |=> !inFetch);
  // R2: execution always begins at step 0
  a_r2_exec_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    inFetch |=> (stepIdx == '0));
  // R13: step counter never leaves the longest sequence
  a_r13_step_bounded: assert property (@(posedge clk) disable iff (!rstN)
    !inFetch |-> (int'(stepIdx) < MAX_STEPS));
endmodule

// File: rtl/seqStrobeDecode.sv
module seqStrobeDecode
  import seqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  uopT    uopIn,
  output strobeT strobes
);
  always_comb begin
    strobes = '0;
    case (uopIn)
      UOP_FETCH: begin
        strobes.selP = 1'b1; strobes.memRead = 1'b1;
        strobes.pInc = 1'b1; strobes.iLoad   = 1'b1;
      end
      UOP_IMM_TO_RN: begin
        strobes.selP  = 1'b1; strobes.memRead = 1'b1;
        strobes.clkRN = 1'b1; strobes.pInc    = 1'b1;
      end
      UOP_ADD_AR: begin
        strobes.selA = 1'b1; strobes.selR = 1'b1; strobes.clkA = 1'b1;
      end
      UOP_IND_TO_RN: begin
        strobes.selR = 1'b1; strobes.memRead = 1'b1; strobes.clkRN = 1'b1;
      end
      UOP_R_TO_A: begin
        strobes.selR = 1'b1; strobes.clkA = 1'b1;
      end
      UOP_A_TO_T: begin
        strobes.selA = 1'b1; strobes.clkT = 1'b1;
      end
      UOP_IMM_TO_A: begin
        strobes.selP = 1'b1; strobes.memRead = 1'b1;
        strobes.clkA = 1'b1; strobes.pInc    = 1'b1;
      end
      UOP_T_TO_MEM: begin
        strobes.selA = 1'b1; strobes.driveT = 1'b1; strobes.memWrite = 1'b1;
      end
      UOP_T_TO_RN: begin
        strobes.driveT = 1'b1; strobes.clkRN = 1'b1;
      end
      UOP_JUMP: begin
        strobes.selP = 1'b1; strobes.selR = 1'b1; strobes.clkP = 1'b1;
      end
      UOP_IND_TO_T: begin
        strobes.selR = 1'b1; strobes.memRead = 1'b1; strobes.clkT = 1'b1;
      end
      UOP_SUB_AN: begin
        strobes.selA = 1'b1; strobes.selN = 1'b1;
        strobes.carryIn = 1'b1; strobes.clkA = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  a_r11_no_rw_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.memRead && strobes.memWrite));
  a_r11_one_left: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.selP && strobes.selA));
  a_r11_one_right: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.selR && strobes.selN));
  a_r9_carry_with_inv: assert property (@(posedge clk) disable iff (!rstN)
    strobes.carryIn |-> (strobes.selN && strobes.selA));
  a_r2_inc_reads_p: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pInc |-> (strobes.memRead && strobes.selP));
endmodule

// File: rtl/microSeq.sv
module microSeq
  import seqPkg::*;
#(
  parameter int INSTR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrIn,
  output logic               selP,
  output logic               selA,
  output logic               selR,
  output logic               selN,
  output logic               driveT,
  output logic               memRead,
  output logic               clkP,
  output logic               clkA,
  output logic               clkRN,
  output logic               clkT,
  output logic               memWrite,
  output logic               carryIn,
  output logic               pInc,
  output logic               iLoad
);
  localparam int HI_W = INSTR_W - OP_W;

  uopT    curUop;
  strobeT strb;

  // Upper instruction bits carry no control meaning (R12)
  logic unusedHiBits;
  assign unusedHiBits = ^instrIn[INSTR_W-1:INSTR_W-HI_W];

  seqControl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .opBits (instrIn[OP_W-1:0]),
    .uopOut (curUop)
  );

  seqStrobeDecode uDec (
    .clk     (clk),
    .rstN    (rstN),
    .uopIn   (curUop),
    .strobes (strb)
  );

  assign selP     = strb.selP;
  assign selA     = strb.selA;
  assign selR     = strb.selR;
  assign selN     = strb.selN;
  assign driveT   = strb.driveT;
  assign memRead  = strb.memRead;
  assign clkP     = strb.clkP;
  assign clkA     = strb.clkA;
  assign clkRN    = strb.clkRN;
  assign clkT     = strb.clkT;
  assign memWrite = strb.memWrite;
  assign carryIn  = strb.carryIn;
  assign pInc     = strb.pInc;
  assign iLoad    = strb.iLoad;
endmodule

// File: tb/sim_microSeq.sv
module sim_microSeq;
  localparam int CLK_PERIOD = 10;
  localparam int INSTR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [INSTR_W-1:0] instrIn = '0;
  logic selP, selA, selR, selN, driveT, memRead, clkP, clkA, clkRN, clkT;
  logic memWrite, carryIn, pInc, iLoad;

  int nVec = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  microSeq #(.INSTR_W(INSTR_W)) u0 (
    .clk(clk), .rstN(rstN), .instrIn(instrIn),
    .selP(selP), .selA(selA), .selR(selR), .selN(selN), .driveT(driveT),
    .memRead(memRead), .clkP(clkP), .clkA(clkA), .clkRN(clkRN), .clkT(clkT),
    .memWrite(memWrite), .carryIn(carryIn), .pInc(pInc), .iLoad(iLoad)
  );

  // Bit positions in the bench's packed view of the outputs
  localparam int B_SP = 13, B_SA = 12, B_SR = 11, B_SN = 10, B_DT = 9, B_MR = 8;
  localparam int B_CP = 7, B_CA = 6, B_CRN = 5, B_CT = 4, B_MW = 3, B_CI = 2;
  localparam int B_PI = 1, B_IL = 0;

  localparam logic [13:0] W_FETCH = 14'((1<<B_SP)|(1<<B_MR)|(1<<B_PI)|(1<<B_IL));
  localparam logic [13:0] W_IMMR  = 14'((1<<B_SP)|(1<<B_MR)|(1<<B_CRN)|(1<<B_PI));
  localparam logic [13:0] W_ADD   = 14'((1<<B_SA)|(1<<B_SR)|(1<<B_CA));
  localparam logic [13:0] W_INDR  = 14'((1<<B_SR)|(1<<B_MR)|(1<<B_CRN));
  localparam logic [13:0] W_RA    = 14'((1<<B_SR)|(1<<B_CA));
  localparam logic [13:0] W_AT    = 14'((1<<B_SA)|(1<<B_CT));
  localparam logic [13:0] W_IMMA  = 14'((1<<B_SP)|(1<<B_MR)|(1<<B_CA)|(1<<B_PI));
  localparam logic [13:0] W_WR    = 14'((1<<B_SA)|(1<<B_DT)|(1<<B_MW));
  localparam logic [13:0] W_TR    = 14'((1<<B_DT)|(1<<B_CRN));
  localparam logic [13:0] W_JMP   = 14'((1<<B_SP)|(1<<B_SR)|(1<<B_CP));
  localparam logic [13:0] W_INDT  = 14'((1<<B_SR)|(1<<B_MR)|(1<<B_CT));
  localparam logic [13:0] W_SUB   = 14'((1<<B_SA)|(1<<B_SN)|(1<<B_CI)|(1<<B_CA));

  function automatic logic [13:0] outWord();
    return {selP, selA, selR, selN, driveT, memRead, clkP, clkA, clkRN, clkT,
            memWrite, carryIn, pInc, iLoad};
  endfunction

  function automatic int opLen(int op);
    case (op)
      1, 3: return 3;
      4, 6: return 5;
      default: return 2;
    endcase
  endfunction

  function automatic logic [13:0] expWord(int op, int st);
    case (op)
      0: return (st == 0) ? W_IMMR : W_ADD;
      1: return (st == 0) ? W_IMMR : (st == 1) ? W_INDR : W_ADD;
      2: return (st == 0) ? W_IMMR : W_RA;
      3, 4: case (st)
        0: return W_AT;
        1: return W_IMMA;
        2: return W_WR;
        3: return W_TR;
        default: return W_RA;
      endcase
      5: return (st == 0) ? W_IMMR : W_JMP;
      6: case (st)
        0: return W_IMMR;
        1: return W_INDT;
        2: return W_IMMR;
        3: return W_RA;
        default: return W_WR;
      endcase
      default: return (st == 0) ? W_IMMR : W_SUB;
    endcase
  endfunction

  function automatic string opReq(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: outputs=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chkExcl();
    logic [13:0] w;
    w = outWord();
    chk("R11", {11'd0, w[B_MR] & w[B_MW], w[B_SP] & w[B_SA], w[B_SR] & w[B_SN]}, 14'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    // R1: reset holds fetch
    repeat (3) @(negedge clk);
    chk("R1", outWord(), W_FETCH);
    rstN = 1'b1;
    chk("R1", outWord(), W_FETCH);

    // Exhaustive sweep: every opcode under every upper-bit pattern (R12)
    for (int hi = 0; hi < (1 << (INSTR_W - 3)); hi++) begin
      for (int op = 0; op < 8; op++) begin
        string tag;
        tag = (hi != 0) ? {opReq(op), "/R12"} : opReq(op);
        chk((op == 0 && hi == 0) ? "R2" : "R10", outWord(), W_FETCH);
        instrIn = INSTR_W'((hi << 3) | op);
        for (int st = 0; st < opLen(op); st++) begin
          @(negedge clk);
          chk(tag, outWord(), expWord(op, st));
          chkExcl();
        end
        @(negedge clk);
      end
    end

    // R13: I changes mid-move so the step lies past add-immediate's end
    chk("R10", outWord(), W_FETCH);
    instrIn = 8'd6;
    repeat (3) @(negedge clk);
    chk("R8", outWord(), W_IMMR);
    instrIn = 8'd0;
    #1;
    chk("R13", outWord(), 14'd0);
    @(negedge clk);
    chk("R13", outWord(), W_FETCH);

    // R1: asynchronous reset in the middle of an instruction
    instrIn = 8'd6;
    repeat (2) @(negedge clk);
    chk("R8", outWord(), W_INDT);
    rstN = 1'b0;
    #1;
    chk("R1", outWord(), W_FETCH);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1", outWord(), W_FETCH);
    @(negedge clk);
    chk("R2", outWord(), W_IMMR);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule